// File: doc/BRIEF.md
# Sticky Error Status Register with Set/Clear Strobes

This block keeps the status word of a serial controller: an enable bit, a master-select bit and six sticky error flags. Software never loads the flags as a value. It writes a 16-bit strobe word instead. Each flag has one bit in that word that sets it and another bit that clears it. Writing 0 to a strobe bit has no effect.

Hardware event pulses can also set the error flags: transmit and receive overflow, transmit and receive underflow, abort, and mode error. Each event except mode error sets its flag only while its gate input from the control register is high. Any error flag that is set holds the level-sensitive error interrupt high.

The enable flag selects the operating mode. When it is clear the controller is in configuration mode, and when it is set the controller is operational. A busy input and a 3-bit received-byte-valid count come from the shifter logic and pass straight into the status word.

Top module: `errflag_reg`

## Requirements
- R1: After reset every flag is 0, so the status word holds only busy (bit 13) and the byte-valid count (bits 30:28), and the error interrupt is low.
- R2: A write whose strobe bit is 1 sets the flag in the next cycle. Strobe bits 1, 3, 5 and 7 set enable, master, receive underflow and mode error. Strobe bits 12, 13, 14 and 15 set transmit overflow, receive overflow, abort and transmit underflow.
- R3: A write whose strobe bit is 1 clears the flag in the next cycle. Strobe bits 0, 2, 4 and 6 clear enable, master, receive underflow and mode error. Strobe bits 8, 9, 10 and 11 clear transmit overflow, receive overflow, abort and transmit underflow.
- R4: Strobe bits written as 0, and any cycle with the write strobe low, leave every flag unchanged.
- R5: If a flag's set and clear strobes are written together, the flag ends at 0.
- R6: A hardware event sets its flag in the next cycle when its gate is 1. The event vector bits are:
  - bit 0: mode error, ungated
  - bits 1 to 5: transmit overflow, receive overflow, abort, transmit underflow and receive underflow
  
  These are gated by gate bits 0 to 4 in the same order.
- R7: A gated event whose gate is 0 does not change its flag.
- R8: A hardware event that arrives in the same cycle as a software clear of its flag leaves the flag at 1.
- R9: The error interrupt is the OR of the six error flags only. Enable and master have no effect on it. It falls in the cycle after the last error flag is cleared.
- R10: Status bit positions are: enable 0, master 1, mode error 7, transmit overflow 8, receive overflow 9, abort 10, transmit underflow 11, receive underflow 12, busy 13, byte-valid count 30:28. All other bits read 0. Busy and the count appear in the same cycle they are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strb_we_i | input | 1 | Strobe-word write enable |
| strb_data_i | input | 16 | Strobe word, one set bit and one clear bit per flag |
| ev_i | input | 6 | Hardware error events (bit 0 mode error, 1..5 gated events) |
| gate_i | input | 5 | Per-error enables for events 1..5 |
| busy_i | input | 1 | Busy indication passed to status bit 13 |
| rxbv_i | input | 3 | Received-byte-valid count passed to status bits 30:28 |
| status_o | output | 32 | Assembled status word |
| err_irq_o | output | 1 | Level error interrupt |

## Verification
The assertions assume the event, gate and strobe inputs are synchronous and stable around the rising edge. They also assume that an interrupt can only fall because software cleared a flag, so no outside agent resets state except `rst_n`. The stimulus changes every input on the falling edge only. It applies reset once at the start, and after that flags drop only through strobe writes.

// File: rtl/errflag_pkg.sv
package errflag_pkg;
  localparam int NFLAG  = 8;   // enable, master, six errors
  localparam int NGATED = 5;
  localparam int NEV    = NGATED + 1;
  localparam int STRB_W = 16;
  localparam int STAT_W = 32;
  localparam int RXBV_W = 3;
  localparam int BUSY_POS = 13;
  localparam int RXBV_LSB = 28;
  localparam int ERR_LO = 2;   // first error flag index

  // internal flag order: 0 enable, 1 master, 2 mode err, 3 tx ovf,
  // 4 rx ovf, 5 abort, 6 tx und, 7 rx und
  function automatic int clr_pos(input int f);
    case (f)
      0: return 0;
      1: return 2;
      2: return 6;
      3: return 8;
      4: return 9;
      5: return 10;
      6: return 11;
      default: return 4;
    endcase
  endfunction

  function automatic int set_pos(input int f);
    return (f >= 3 && f <= 6) ? clr_pos(f) + 4 : clr_pos(f) + 1;
  endfunction

  function automatic int stat_pos(input int f);
    return (f < 2) ? f : f + 5;
  endfunction
endpackage

// File: rtl/errflag_strobe_dec.sv
module errflag_strobe_dec
  import errflag_pkg::*;
(
  input  logic              we_i,
  input  logic [STRB_W-1:0] data_i,
  output logic [NFLAG-1:0]  set_o,
  output logic [NFLAG-1:0]  clr_o
);
  for (genvar f = 0; f < NFLAG; f++) begin : g_dec
    assign set_o[f] = we_i & data_i[set_pos(f)];
    assign clr_o[f] = we_i & data_i[clr_pos(f)];
  end
endmodule

// File: rtl/errflag_gate.sv
module errflag_gate
  import errflag_pkg::*;
(
  input  logic [NEV-1:0]    ev_i,
  input  logic [NGATED-1:0] gate_i,
  output logic [NFLAG-1:0]  hw_set_o
);
  assign hw_set_o[0]      = 1'b0;
  assign hw_set_o[1]      = 1'b0;
  assign hw_set_o[ERR_LO] = ev_i[0];
  for (genvar g = 0; g < NGATED; g++) begin : g_gate
    assign hw_set_o[ERR_LO+1+g] = ev_i[1+g] & gate_i[g];
  end
endmodule

// File: rtl/errflag_cell.sv
module errflag_cell #(
  parameter bit HW_SETTABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  input  logic hw_set_i,
  output logic q_o
);
  logic hw_set_eff;
  logic nxt;

  if (HW_SETTABLE) begin : g_hw
    assign hw_set_eff = hw_set_i;
  end else begin : g_sw
    assign hw_set_eff = 1'b0;
  end

  // hardware event beats clear, clear beats software set
  always_comb begin
    if (hw_set_eff)    nxt = 1'b1;
    else if (sw_clr_i) nxt = 1'b0;
    else if (sw_set_i) nxt = 1'b1;
    else               nxt = q_o;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= nxt;

  // R5: clear wins over software set
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_i && !hw_set_eff) |=> !q_o);
  // R2 / R6: a set without clear takes effect next cycle
  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_set_i || hw_set_eff) && !sw_clr_i) |=> q_o);
  // R4: no strobe and no event, flag holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_set_i && !sw_clr_i && !hw_set_eff) |=> $stable(q_o));
  // R8: event colliding with clear is kept
  a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_i && hw_set_eff) |=> q_o);
endmodule

// File: rtl/errflag_reg.sv
module errflag_reg
  import errflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_we_i,
  input  logic [15:0]       strb_data_i,
  input  logic [5:0]        ev_i,
  input  logic [4:0]        gate_i,
  input  logic              busy_i,
  input  logic [2:0]        rxbv_i,
  output logic [31:0]       status_o,
  output logic              err_irq_o
);
  logic [NFLAG-1:0] sw_set, sw_clr, hw_set, flags;

  errflag_strobe_dec i_dec (
    .we_i(strb_we_i), .data_i(strb_data_i), .set_o(sw_set), .clr_o(sw_clr));

  errflag_gate i_gate (.ev_i(ev_i), .gate_i(gate_i), .hw_set_o(hw_set));

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    errflag_cell #(.HW_SETTABLE(f >= ERR_LO)) i_cell (
      .clk(clk), .rst_n(rst_n), .sw_set_i(sw_set[f]), .sw_clr_i(sw_clr[f]),
      .hw_set_i(hw_set[f]), .q_o(flags[f]));
  end

  always_comb begin
    status_o = '0;
    for (int f = 0; f < NFLAG; f++) status_o[stat_pos(f)] = flags[f];
    status_o[BUSY_POS] = busy_i;
    status_o[RXBV_LSB +: RXBV_W] = rxbv_i;
  end

  assign err_irq_o = |flags[NFLAG-1:ERR_LO];

  // R9: the interrupt only falls after a software strobe write
  a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_irq_o) |-> $past(strb_we_i));
  // R9: interrupt rises only from a set strobe or an event
  a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq_o) |-> $past(strb_we_i || (|ev_i)));

  // R7: an event whose gate is low never sets its flag
  for (genvar g = 0; g < NGATED; g++) begin : g_chk
    a_r7_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i[1+g] && !gate_i[g] && !sw_set[ERR_LO+1+g] && !flags[ERR_LO+1+g])
      |=> !status_o[stat_pos(ERR_LO+1+g)]);
  end
endmodule

// File: tb/test_errflag_reg.sv
module test_errflag_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [15:0] wdata = '0;
  logic [5:0] ev = '0;
  logic [4:0] gate = '0;
  logic busy = 1'b0;
  logic [2:0] rxbv = '0;
  logic [31:0] status;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] q_st[$];
  logic        q_irq[$];
  string       q_tag[$];

  // bench model, flag order: en, ms, me, te, re, ae, tue, rue
  logic [7:0] m = '0;
  int clr_tab[8] = '{0, 2, 6, 8, 9, 10, 11, 4};
  int set_tab[8] = '{1, 3, 7, 12, 13, 14, 15, 5};

  always #4 clk = ~clk;

  errflag_reg i_errflag_reg (
    .clk(clk), .rst_n(rst_n), .strb_we_i(we), .strb_data_i(wdata),
    .ev_i(ev), .gate_i(gate), .busy_i(busy), .rxbv_i(rxbv),
    .status_o(status), .err_irq_o(irq));

  function automatic logic [31:0] build(input logic [7:0] fl, input logic b,
                                        input logic [2:0] cnt);
    logic [31:0] s = '0;
    s[0] = fl[0];
    s[1] = fl[1];
    s[7] = fl[2];
    s[12:8] = {fl[7], fl[6], fl[5], fl[4], fl[3]};
    s[13] = b;
    s[30:28] = cnt;
    return s;
  endfunction

  task automatic step(input logic w, input logic [15:0] d, input logic [5:0] e,
                      input logic [4:0] g, input logic b, input logic [2:0] c,
                      input string tag);
    logic [7:0] hw;
    @(negedge clk);
    we = w; wdata = d; ev = e; gate = g; busy = b; rxbv = c;
    hw = {e[5] & g[4], e[4] & g[3], e[3] & g[2], e[2] & g[1], e[1] & g[0],
          e[0], 1'b0, 1'b0};
    for (int i = 0; i < 8; i++) begin
      logic s, k;
      s = w & d[set_tab[i]];
      k = w & d[clr_tab[i]];
      m[i] = hw[i] | (~k & (s | m[i]));
    end
    q_st.push_back(build(m, b, c));
    q_irq.push_back(|m[7:2]);
    q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q_st.size() > 0) begin
      logic [31:0] es;
      logic ei;
      string t;
      es = q_st.pop_front();
      ei = q_irq.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (status !== es || irq !== ei) begin
        fails++;
        $display("FAIL %s status=%h irq=%b expected status=%h irq=%b",
                 t, status, irq, es, ei);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R10 passthrough
    step(0, 16'h0, 6'h0, 5'h0, 1'b0, 3'd0, "R1");
    step(0, 16'h0, 6'h0, 5'h0, 1'b1, 3'd5, "R1 R10");
    // R2 each set strobe individually, R3 each clear
    for (int i = 0; i < 8; i++) begin
      step(1, 16'h1 << set_tab[i], 6'h0, 5'h0, 1'b0, 3'(i), "R2");
      step(1, 16'h1 << clr_tab[i], 6'h0, 5'h0, 1'b1, 3'd2, "R3");
    end
    // R2/R9 set all, R3 config mode entry
    step(1, 16'hF0AA, 6'h0, 5'h0, 1'b0, 3'd7, "R2");
    step(1, 16'h0001, 6'h0, 5'h0, 1'b0, 3'd0, "R3");
    // R4 write strobe low and zero data
    step(0, 16'h5555, 6'h0, 5'h0, 1'b0, 3'd0, "R4");
    step(1, 16'h0000, 6'h0, 5'h0, 1'b0, 3'd0, "R4");
    // R9 clear errors one by one; irq falls after last
    step(1, 16'h0F00, 6'h0, 5'h0, 1'b0, 3'd0, "R9");
    step(1, 16'h0010, 6'h0, 5'h0, 1'b0, 3'd0, "R9");
    step(1, 16'h0040, 6'h0, 5'h0, 1'b0, 3'd0, "R9");
    step(0, 16'h0000, 6'h0, 5'h0, 1'b0, 3'd0, "R9");
    // R9 enable/master do not drive irq
    step(1, 16'h000A, 6'h0, 5'h0, 1'b0, 3'd0, "R9");
    // R5 set and clear together: clear wins
    step(1, 16'h00C0, 6'h0, 5'h0, 1'b0, 3'd0, "R5");
    step(1, 16'h0080, 6'h0, 5'h0, 1'b0, 3'd0, "R5");
    step(1, 16'hFFFF, 6'h0, 5'h0, 1'b0, 3'd0, "R5");
    // R7 gates low: only mode error is set
    step(0, 16'h0, 6'h3F, 5'h00, 1'b0, 3'd0, "R7");
    step(0, 16'h0, 6'h00, 5'h00, 1'b0, 3'd0, "R7");
    step(1, 16'h0040, 6'h0, 5'h0, 1'b0, 3'd0, "R7");
    // R6 each gated event with its gate
    for (int g = 0; g < 5; g++) begin
      step(0, 16'h0, 6'h1 << (g + 1), 5'h1 << g, 1'b0, 3'd1, "R6");
      step(0, 16'h0, 6'h3E, 5'h1F ^ (5'h1 << g), 1'b0, 3'd1, "R7");
    end
    // R8 event during clear keeps flags
    step(1, 16'h0F50, 6'h3F, 5'h1F, 1'b0, 3'd0, "R8");
    step(1, 16'h0F50, 6'h00, 5'h1F, 1'b0, 3'd0, "R8");
    step(0, 16'h0, 6'h0, 5'h0, 1'b0, 3'd0, "R9");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule